// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A one-cycle pulse on `secTick`, raised once per second by an external divider, advances the seconds. Carries then ripple, in the same clock edge, through minutes, hours, weekday, date, month and year. The date wraps at the true length of each month, and February gets a 29th day in leap years.

A host loads any register through a synchronous write port. It reads any register back through a combinational read port. The hours register runs in either 24-hour or 12-hour form, chosen by a mode bit stored in the register itself. The month register carries a century flag that flips each time the two-digit year wraps. A sticky status flag reports that timekeeping was lost. It comes up set after reset and stays set until the host clears it.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, addresses 0..6 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 (seconds, minutes, hours in 24-hour form, weekday, date, month, year), and the status register at address 15 reads 0x80.
- R2: Seconds count 00..59 in BCD. A tick at 59 gives 00 and advances minutes. Minutes at 59 wrap to 00 on that carry and advance hours.
- R3: With hours bit 6 clear (24-hour form), hours count 00..23. A carry at 23 gives 00 and advances both weekday and date.
- R4: With hours bit 6 set (12-hour form), bit 5 is PM and bits 4:0 hold the BCD hour 01..12. A carry at 11 gives 12 and flips bit 5. A carry at 12 gives 01. Only the step from 11 PM to 12 AM advances weekday and date.
- R5: Weekday counts 1..7, and a day carry at 7 gives 1.
- R6: The date wraps to 01 and advances the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. Month 12 wraps to 01 and advances the year.
- R7: February wraps after day 29 when the BCD year value is divisible by 4 (00 included), and after day 28 otherwise.
- R8: When the year wraps from 99 to 00, bit 7 of the month register (the century flag) toggles.
- R9: A host write to any of addresses 0..6 stores `wrData` under that register's valid-bit mask. A tick in the same cycle is dropped for all registers.
- R10: `rdData` shows the register at `rdAddr` in the same cycle. Unused addresses and unused bits (month bits 6:5, weekday bits 7:3, date bits 7:6, bit 7 of seconds, minutes and hours) read 0.
- R11: Status bit 7 is the oscillator-stop flag. It is set by reset. A status write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged. A status write does not block a tick.
- R12: Without a tick or a write, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | 8 | Host write data |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | 8 | Register contents at `rdAddr` |

## Verification
Some properties are checked by assertions on every cycle:
- seconds return to zero whenever the minute carries;
- the PM bit flips on each 11-to-12 step;
- the century flag flips with every year wrap;
- a time write always lands and suppresses that cycle's tick;
- the oscillator-stop flag never drops except through a clearing write;
- the date never wraps below 28.

Other behaviour can only be shown by the bench scenarios. These cover:
- which day each month wraps after;
- the leap-year rule across several years;
- the chained rollover from New Year's Eve through the century;
- the exact 12-hour sequence 11 AM, 12 PM, 1 PM and 11 PM, 12 AM, 1 AM;
- the values read back through the port after each step.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_TIME = 7;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  typedef struct packed {
    logic [NUM_TIME-1:0] wrSel;
    logic statWr;
    logic secStep;
    logic minStep;
    logic hourStep;
    logic dayStep;
    logic monStep;
    logic yearStep;
    logic centStep;
  } stepCtl_t;

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [BYTE_W-1:0] fieldMask(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN, IDX_HOUR: return 8'h7F;
      IDX_WDAY: return 8'h07;
      IDX_DATE: return 8'h3F;
      IDX_MON: return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] resetVal(input int idx);
    case (idx)
      IDX_WDAY, IDX_DATE, IDX_MON: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_ctrl.sv
module bcd_cal_ctrl
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STAT_ADDR = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic secTick,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NUM_TIME-1:0][BYTE_W-1:0] cur,
  output stepCtl_t step
);
  logic leapYear;
  logic [BYTE_W-1:0] lastDay;
  logic hourWrap;
  logic timeWr;

  // Year divisible by 4: even tens digit with units 0/4/8, odd tens digit with units 2/6.
  always_comb begin
    if (cur[IDX_YEAR][4])
      leapYear = (cur[IDX_YEAR][3:0] == 4'd2) || (cur[IDX_YEAR][3:0] == 4'd6);
    else
      leapYear = (cur[IDX_YEAR][3:0] == 4'd0) || (cur[IDX_YEAR][3:0] == 4'd4) ||
                 (cur[IDX_YEAR][3:0] == 4'd8);
  end

  always_comb begin
    case (cur[IDX_MON][4:0])
      5'h02: lastDay = leapYear ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: lastDay = 8'h30;
      default: lastDay = 8'h31;
    endcase
  end

  always_comb begin
    if (cur[IDX_HOUR][6])
      hourWrap = cur[IDX_HOUR][5] && (cur[IDX_HOUR][4:0] == 5'h11);
    else
      hourWrap = (cur[IDX_HOUR][5:0] == 6'h23);
  end

  generate
    for (genvar i = 0; i < NUM_TIME; i++) begin : g_sel
      assign step.wrSel[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
  endgenerate

  assign timeWr        = |step.wrSel;
  assign step.statWr   = wrEn && (wrAddr == ADDR_W'(STAT_ADDR));
  assign step.secStep  = secTick && !timeWr;
  assign step.minStep  = step.secStep  && (cur[IDX_SEC] == 8'h59);
  assign step.hourStep = step.minStep  && (cur[IDX_MIN] == 8'h59);
  assign step.dayStep  = step.hourStep && hourWrap;
  assign step.monStep  = step.dayStep  && (cur[IDX_DATE] == lastDay);
  assign step.yearStep = step.monStep  && (cur[IDX_MON][4:0] == 5'h12);
  assign step.centStep = step.yearStep && (cur[IDX_YEAR] == 8'h99);

  // R9
  tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr < ADDR_W'(NUM_TIME)) |-> !step.secStep);

  // R6
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step.monStep |-> (cur[IDX_DATE] >= 8'h28));
endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STAT_ADDR = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  stepCtl_t step,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [NUM_TIME-1:0][BYTE_W-1:0] cur,
  output logic [BYTE_W-1:0] rdData
);
  logic [NUM_TIME-1:0][BYTE_W-1:0] regArr;
  logic [NUM_TIME-1:0][BYTE_W-1:0] nextArr;
  logic [NUM_TIME-1:0] advance;
  logic oscStop;
  logic [BYTE_W-1:0] hrInc;
  logic [BYTE_W-1:0] hr12Inc;

  assign advance[IDX_SEC]  = step.secStep;
  assign advance[IDX_MIN]  = step.minStep;
  assign advance[IDX_HOUR] = step.hourStep;
  assign advance[IDX_WDAY] = step.dayStep;
  assign advance[IDX_DATE] = step.dayStep;
  assign advance[IDX_MON]  = step.monStep;
  assign advance[IDX_YEAR] = step.yearStep;

  assign hrInc   = bcdInc({2'b00, regArr[IDX_HOUR][5:0]});
  assign hr12Inc = bcdInc({3'b000, regArr[IDX_HOUR][4:0]});

  always_comb begin
    nextArr = regArr;
    nextArr[IDX_SEC] = step.minStep ? 8'h00 : bcdInc(regArr[IDX_SEC]);
    nextArr[IDX_MIN] = step.hourStep ? 8'h00 : bcdInc(regArr[IDX_MIN]);
    if (regArr[IDX_HOUR][6]) begin
      if (regArr[IDX_HOUR][4:0] == 5'h12)
        nextArr[IDX_HOUR] = {regArr[IDX_HOUR][7:5], 5'h01};
      else if (regArr[IDX_HOUR][4:0] == 5'h11)
        nextArr[IDX_HOUR] = {regArr[IDX_HOUR][7:6], ~regArr[IDX_HOUR][5], 5'h12};
      else
        nextArr[IDX_HOUR] = {regArr[IDX_HOUR][7:5], hr12Inc[4:0]};
    end else begin
      nextArr[IDX_HOUR] = step.dayStep ? {regArr[IDX_HOUR][7:6], 6'h00}
                                       : {regArr[IDX_HOUR][7:6], hrInc[5:0]};
    end
    nextArr[IDX_WDAY] = (regArr[IDX_WDAY] >= 8'h07) ? 8'h01 : regArr[IDX_WDAY] + 8'h01;
    nextArr[IDX_DATE] = step.monStep ? 8'h01 : bcdInc(regArr[IDX_DATE]);
    nextArr[IDX_MON]  = {regArr[IDX_MON][7] ^ step.centStep, 2'b00,
                         (regArr[IDX_MON][4:0] == 5'h12) ? 5'h01
                                                          : bcdInc({3'b000, regArr[IDX_MON][4:0]})[4:0]};
    nextArr[IDX_YEAR] = step.centStep ? 8'h00 : bcdInc(regArr[IDX_YEAR]);
  end

  generate
    for (genvar i = 0; i < NUM_TIME; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          regArr[i] <= resetVal(i);
        else if (step.wrSel[i])
          regArr[i] <= wrData & fieldMask(i);
        else if (advance[i])
          regArr[i] <= nextArr[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      oscStop <= 1'b1;
    else if (step.statWr && !wrData[7])
      oscStop <= 1'b0;
  end

  assign cur = regArr;

  always_comb begin
    if (rdAddr < ADDR_W'(NUM_TIME))
      rdData = regArr[rdAddr[$clog2(NUM_TIME)-1:0]];
    else if (rdAddr == ADDR_W'(STAT_ADDR))
      rdData = {oscStop, 7'b0};
    else
      rdData = '0;
  end

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step.minStep |=> (regArr[IDX_SEC] == 8'h00));

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step.hourStep && regArr[IDX_HOUR][6] && regArr[IDX_HOUR][4:0] == 5'h11)
      |=> (regArr[IDX_HOUR][5] != $past(regArr[IDX_HOUR][5])));

  // R8
  century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step.centStep |=> (regArr[IDX_MON][7] != $past(regArr[IDX_MON][7])));

  // R9
  wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step.wrSel[IDX_SEC] |=> (regArr[IDX_SEC] == ($past(wrData) & 8'h7F)));

  // R11
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oscStop && !(step.statWr && !wrData[7])) |=> oscStop);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step.secStep && step.wrSel == '0) |=> $stable(regArr));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STAT_ADDR = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic secTick,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0] rdData
);
  stepCtl_t step;
  logic [NUM_TIME-1:0][BYTE_W-1:0] cur;

  bcd_cal_ctrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .cur(cur), .step(step)
  );

  bcd_cal_regs #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .step(step), .wrData(wrData),
    .rdAddr(rdAddr), .cur(cur), .rdData(rdData)
  );
endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic secTick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp;
    string tag;
  } chkItem_t;
  chkItem_t q[$];

  always #2 clk = ~clk;

  bcd_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic expectReg(input logic [3:0] a, input logic [7:0] e, input string tag);
    q.push_back('{addr: a, exp: e, tag: tag});
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    secTick = 1'b1;
    repeat (n) @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                         input logic [7:0] y);
    writeReg(4'd0, s); writeReg(4'd1, m); writeReg(4'd2, h); writeReg(4'd3, w);
    writeReg(4'd4, d); writeReg(4'd5, mo); writeReg(4'd6, y);
  endtask

  // monitor: pops expected items and compares them with the read port
  initial begin
    forever begin
      wait (q.size() != 0);
      @(negedge clk);
      rdAddr = q[0].addr;
      #1;
      total++;
      if (rdData !== q[0].exp) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", q[0].tag, q[0].addr, rdData, q[0].exp);
      end
      void'(q.pop_front());
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expectReg(0, 8'h00, "R1 sec"); expectReg(1, 8'h00, "R1 min");
    expectReg(2, 8'h00, "R1 hour"); expectReg(3, 8'h01, "R1 wday");
    expectReg(4, 8'h01, "R1 date"); expectReg(5, 8'h01, "R1 month");
    expectReg(6, 8'h00, "R1 year"); expectReg(15, 8'h80, "R1 status");
    drain();

    // R12 idle
    repeat (5) @(negedge clk);
    expectReg(0, 8'h00, "R12 idle sec"); drain();

    // R2 seconds and minutes roll
    setTime(8'h58, 8'h59, 8'h05, 8'h02, 8'h10, 8'h05, 8'h23);
    tick(1);
    expectReg(0, 8'h59, "R2 sec 59"); drain();
    tick(1);
    expectReg(0, 8'h00, "R2 sec wrap"); expectReg(1, 8'h00, "R2 min wrap");
    expectReg(2, 8'h06, "R2 hour carry"); drain();

    // R3 24-hour midnight
    setTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h10, 8'h05, 8'h23);
    tick(1);
    expectReg(2, 8'h00, "R3 hour wrap"); expectReg(3, 8'h04, "R3 wday");
    expectReg(4, 8'h11, "R3 date"); drain();

    // R5 weekday wrap
    setTime(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h05, 8'h23);
    tick(1);
    expectReg(3, 8'h01, "R5 wday wrap"); drain();

    // R4 12-hour form
    setTime(8'h59, 8'h59, 8'h51, 8'h02, 8'h05, 8'h05, 8'h23);
    tick(1);
    expectReg(2, 8'h72, "R4 11AM->12PM"); expectReg(4, 8'h05, "R4 no day"); drain();
    setTime(8'h59, 8'h59, 8'h72, 8'h02, 8'h05, 8'h05, 8'h23);
    tick(1);
    expectReg(2, 8'h61, "R4 12PM->1PM"); drain();
    setTime(8'h59, 8'h59, 8'h71, 8'h02, 8'h05, 8'h05, 8'h23);
    tick(1);
    expectReg(2, 8'h52, "R4 11PM->12AM"); expectReg(4, 8'h06, "R4 day adv");
    expectReg(3, 8'h03, "R4 wday adv"); drain();
    setTime(8'h59, 8'h59, 8'h52, 8'h02, 8'h05, 8'h05, 8'h23);
    tick(1);
    expectReg(2, 8'h41, "R4 12AM->1AM"); drain();

    // R6 month lengths
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h04, 8'h23);
    tick(1);
    expectReg(4, 8'h30, "R6 apr 30"); expectReg(5, 8'h04, "R6 apr stays"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    tick(1);
    expectReg(4, 8'h01, "R6 apr wrap"); expectReg(5, 8'h05, "R6 may"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23);
    tick(1);
    expectReg(4, 8'h31, "R6 jan 31"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h23);
    tick(1);
    expectReg(4, 8'h01, "R6 jan wrap"); expectReg(5, 8'h02, "R6 feb"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h24);
    tick(1);
    expectReg(4, 8'h01, "R6 dec wrap"); expectReg(5, 8'h01, "R6 jan");
    expectReg(6, 8'h25, "R6 year adv"); drain();

    // R7 leap years
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick(1);
    expectReg(4, 8'h01, "R7 feb28 wrap 23"); expectReg(5, 8'h03, "R7 mar"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick(1);
    expectReg(4, 8'h29, "R7 feb29 24"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick(1);
    expectReg(4, 8'h01, "R7 feb29 wrap"); expectReg(5, 8'h03, "R7 mar 24"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick(1);
    expectReg(4, 8'h29, "R7 feb29 00"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h38);
    tick(1);
    expectReg(4, 8'h01, "R7 feb28 wrap 38"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h96);
    tick(1);
    expectReg(4, 8'h29, "R7 feb29 96"); drain();

    // R8 century
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    tick(1);
    expectReg(6, 8'h00, "R8 year wrap"); expectReg(5, 8'h81, "R8 century set"); drain();
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h92, 8'h99);
    tick(1);
    expectReg(5, 8'h01, "R8 century clear"); drain();

    // R9 write wins over tick
    setTime(8'h10, 8'h20, 8'h03, 8'h01, 8'h05, 8'h05, 8'h23);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd2; wrData = 8'h07; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    expectReg(0, 8'h10, "R9 tick dropped"); expectReg(2, 8'h07, "R9 hour written"); drain();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd0; wrData = 8'h30; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    expectReg(0, 8'h30, "R9 sec written"); expectReg(1, 8'h20, "R9 min same"); drain();

    // R11 oscillator-stop flag
    writeReg(4'd15, 8'h80);
    expectReg(15, 8'h80, "R11 write1 no effect"); drain();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd15; wrData = 8'h00; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    expectReg(15, 8'h00, "R11 cleared"); expectReg(0, 8'h31, "R11 tick kept"); drain();
    writeReg(4'd15, 8'h80);
    expectReg(15, 8'h00, "R11 no set"); drain();

    // R10 read port and masks
    writeReg(4'd3, 8'hF3);
    writeReg(4'd5, 8'hE7);
    expectReg(3, 8'h03, "R10 wday mask"); expectReg(5, 8'h87, "R10 month mask");
    expectReg(7, 8'h00, "R10 unused 7"); expectReg(14, 8'h00, "R10 unused 14"); drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule